// File: doc/BRIEF.md
# Distance-3 Self-Correcting Four-State Controller

This block is a small control sequencer whose state survives a single bit upset in its state register. The four states, A, B, C and D, are held as 5-bit code words, and any two of those words differ in at least three positions. Each state owns its base word and the five words that sit one bit away from it. A flip of any one register bit therefore leaves the register inside the same state's group. The machine behaves exactly as it did before the flip, and the next clock edge writes the clean base word back.

The per-state decode is a sum of five product terms. Each term fixes four literals to the base word and leaves one bit free. Every move between the base word and one of its neighbours stays inside a single term, so a single flip cannot glitch the decode. A one-cycle `corrected` indication shows that a neighbour word was seen. Eight of the 32 patterns belong to no state. These raise `uncorrectable`, and the machine is forced back to state A on the next edge. An injection port XORs a mask into the register so that upsets can be produced through the block's own pins. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `hd3_fsm_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after its synchronized release, `state_code` reads 00000 and `state_oh` reads 0001 (state A).
- R2: The base words are A=00000, B=11100, C=01111, D=10011. `state_oh` bit 0 marks A, bit 1 B, bit 2 C and bit 3 D.
- R3: With no injection, A moves to B when `go` is high, B to C on `step`, C to D on `step`, and D to A on `done`. Every other input combination keeps the present state.
- R4: A register value one bit away from a base word drives `state_oh` for that base word's state.
- R5: `corrected` is high exactly while the register holds a non-base word of some state. Without injection, the next edge loads a base word, so `corrected` lasts one cycle.
- R6: Transitions taken from a neighbour word are the same as those taken from its base word, and they land on the base word of the target.
- R7: For the 8 patterns that are in no state's group, `uncorrectable` is high and `state_oh` is 0000. The next edge loads 00000 whatever `go`, `step` and `done` are.
- R8: When `inj_en` is high, the next edge loads `state_code ^ inj_mask`, and `go`, `step` and `done` have no effect in that cycle.
- R9: After any edge without injection, the register holds a base word, so `corrected` and `uncorrectable` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| go | input | 1 | Leaves A for B |
| step | input | 1 | Advances B to C and C to D |
| done | input | 1 | Returns D to A |
| inj_en | input | 1 | Replaces the next-state update with an XOR of `inj_mask` into the register |
| inj_mask | input | 5 | Bits to flip when `inj_en` is high |
| state_oh | output | 4 | One-hot decoded state (bit 0 = A ... bit 3 = D), zero when no state matches |
| state_code | output | 5 | Raw state register |
| corrected | output | 1 | Register holds a neighbour word of a state |
| uncorrectable | output | 1 | Register holds a pattern outside every state's group |

## Verification
The bench flips each of the five bits in each of the four states. After every flip it checks that the decode stays on the same state and that the base word returns one edge later. A decoder with a missing product term would drop the state or raise `uncorrectable` for that flip. A register that kept the flipped word would hold `corrected` high for a second cycle. Neighbour words are also combined with live transition inputs, which catches next-state logic that keys on exact base words and stalls. All eight orphan patterns are driven with `go` high to show that recovery to A overrides the controls. Double flips that land in another state's group are followed through the same reference model.

// File: rtl/hd3_fsm_pkg.sv
package hd3_fsm_pkg;
  localparam int CODE_W = 5;
  localparam int NUM_ST = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_A = 5'b00000;
  localparam code_t CODE_B = 5'b11100;
  localparam code_t CODE_C = 5'b01111;
  localparam code_t CODE_D = 5'b10011;

  // Base word of a state by index (0 = A ... 3 = D)
  function automatic code_t base_of(input int idx);
    case (idx)
      0:       return CODE_A;
      1:       return CODE_B;
      2:       return CODE_C;
      default: return CODE_D;
    endcase
  endfunction
endpackage

// File: rtl/hd3_reset_sync.sv
module hd3_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/hd3_ball_decode.sv
// Hazard-free membership test for one state's distance-1 group.
// Term k fixes every literal except bit k to the base word. The base word
// lies in all terms, and neighbour k lies in term k, so a single flip
// always stays inside one product.
module hd3_ball_decode #(
  parameter int           W    = 5,
  parameter logic [W-1:0] BASE = '0
) (
  input  logic [W-1:0] code,
  output logic         hit,
  output logic         exact
);
  logic [W-1:0] lit;
  logic [W-1:0] term;

  for (genvar i = 0; i < W; i++) begin : g_lit
    if (BASE[i]) begin : g_pos
      assign lit[i] = code[i];
    end else begin : g_neg
      assign lit[i] = ~code[i];
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_term
    localparam logic [W-1:0] FREE = W'(1) << k;
    assign term[k] = &(lit | FREE);
  end

  assign hit   = |term;
  assign exact = &lit;
endmodule

// File: rtl/hd3_next_state.sv
module hd3_next_state
  import hd3_fsm_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int N = NUM_ST
) (
  input  logic [N-1:0] hit,
  input  logic [W-1:0] code_q,
  input  logic         go,
  input  logic         step,
  input  logic         done,
  input  logic         inj_en,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] code_d
);
  always_comb begin
    if (inj_en) begin
      code_d = code_q ^ inj_mask;
    end else begin
      unique case (hit)
        4'b0001: code_d = go   ? CODE_B : CODE_A;
        4'b0010: code_d = step ? CODE_C : CODE_B;
        4'b0100: code_d = step ? CODE_D : CODE_C;
        4'b1000: code_d = done ? CODE_A : CODE_D;
        default: code_d = CODE_A;  // orphan pattern: recover to A
      endcase
    end
  end
endmodule

// File: rtl/hd3_fsm_ctrl.sv
module hd3_fsm_ctrl
  import hd3_fsm_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int N = NUM_ST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         step,
  input  logic         done,
  input  logic         inj_en,
  input  logic [W-1:0] inj_mask,
  output logic [N-1:0] state_oh,
  output logic [W-1:0] state_code,
  output logic         corrected,
  output logic         uncorrectable
);
  logic         rst_sync_n;
  logic [W-1:0] code_q, code_d;
  logic [N-1:0] hit, exact;
  logic         code_ld;

  hd3_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar s = 0; s < N; s++) begin : g_dec
    hd3_ball_decode #(.W(W), .BASE(base_of(s))) u_dec (
      .code(code_q), .hit(hit[s]), .exact(exact[s])
    );
  end

  hd3_next_state #(.W(W), .N(N)) u_ns (
    .hit(hit), .code_q(code_q), .go(go), .step(step), .done(done),
    .inj_en(inj_en), .inj_mask(inj_mask), .code_d(code_d)
  );

  // Load whenever the word changes or an injection is requested
  assign code_ld = inj_en | (code_d != code_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  code_q <= CODE_A;
    else if (code_ld) code_q <= code_d;
  end

  assign state_oh      = hit;
  assign state_code    = code_q;
  assign corrected     = (|hit) & ~(|exact);
  assign uncorrectable = ~(|hit);

  // R4
  oh_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uncorrectable || $onehot(state_oh));

  // R5
  corr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corrected && !inj_en) |=> !corrected);

  // R7
  orphan_to_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (uncorrectable && !inj_en) |=> (state_code == CODE_A));

  // R8
  inject_xor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inj_en |=> (state_code == ($past(state_code) ^ $past(inj_mask))));

  // R9
  clean_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inj_en |=> (!corrected && !uncorrectable));

  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == CODE_A && !inj_en && !go) |=> (state_code == CODE_A));
endmodule

// File: tb/tb_hd3_fsm_ctrl.sv
module tb_hd3_fsm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic go, step, done, inj_en;
  logic [4:0] inj_mask;
  logic [3:0] state_oh;
  logic [4:0] state_code;
  logic corrected, uncorrectable;

  hd3_fsm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .go(go), .step(step), .done(done),
    .inj_en(inj_en), .inj_mask(inj_mask), .state_oh(state_oh),
    .state_code(state_code), .corrected(corrected),
    .uncorrectable(uncorrectable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [4:0] code;
    logic [3:0] oh;
    logic       corr;
    logic       unc;
    string      req;
  } exp_t;

  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [4:0] mcode;

  // Reference words from R2
  function automatic logic [4:0] ref_base(input int s);
    case (s)
      0: return 5'b00000;
      1: return 5'b11100;
      2: return 5'b01111;
      default: return 5'b10011;
    endcase
  endfunction

  // State whose group contains c, or -1 for an orphan pattern
  function automatic int ref_state(input logic [4:0] c);
    for (int s = 0; s < 4; s++)
      if ($countones(c ^ ref_base(s)) <= 1) return s;
    return -1;
  endfunction

  function automatic exp_t ref_exp(input logic [4:0] c, input string r);
    exp_t e;
    int s = ref_state(c);
    e.code = c;
    e.oh   = (s >= 0) ? 4'(1 << s) : 4'b0000;
    e.corr = (s >= 0) && (c != ref_base(s));
    e.unc  = (s < 0);
    e.req  = r;
    return e;
  endfunction

  function automatic logic [4:0] ref_next(input logic [4:0] c, input logic g,
      input logic st, input logic d, input logic ie, input logic [4:0] m);
    int s = ref_state(c);
    if (ie) return c ^ m;
    case (s)
      0: return g  ? ref_base(1) : ref_base(0);
      1: return st ? ref_base(2) : ref_base(1);
      2: return st ? ref_base(3) : ref_base(2);
      3: return d  ? ref_base(0) : ref_base(3);
      default: return ref_base(0);
    endcase
  endfunction

  task automatic compare(input exp_t e);
    n_cmp++;
    if (state_code !== e.code || state_oh !== e.oh ||
        corrected !== e.corr || uncorrectable !== e.unc) begin
      n_bad++;
      $display("FAIL %s: code=%b oh=%b corr=%b unc=%b expected code=%b oh=%b corr=%b unc=%b",
               e.req, state_code, state_oh, corrected, uncorrectable,
               e.code, e.oh, e.corr, e.unc);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed after the edge
  task automatic cyc(input logic g, input logic st, input logic d,
                     input logic ie, input logic [4:0] m, input string r);
    logic [4:0] nxt;
    @(negedge clk);
    go = g; step = st; done = d; inj_en = ie; inj_mask = m;
    nxt = ref_next(mcode, g, st, d, ie, m);
    @(posedge clk);
    mcode = nxt;
    sb.push_back(ref_exp(mcode, r));
  endtask

  // Steer the machine to state tgt using only legal transitions
  task automatic move_to(input int tgt);
    for (int n = 0; n < 8 && ref_state(mcode) != tgt; n++) begin
      case (ref_state(mcode))
        0: cyc(1, 0, 0, 0, 5'b0, "R3");
        1: cyc(0, 1, 0, 0, 5'b0, "R3");
        2: cyc(0, 1, 0, 0, 5'b0, "R3");
        default: cyc(0, 0, 1, 0, 5'b0, "R3");
      endcase
    end
  endtask

  // Monitor: compare the oldest expected item away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) compare(sb.pop_front());
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; go = 0; step = 0; done = 0; inj_en = 0; inj_mask = '0;
    mcode = 5'b00000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(ref_exp(5'b00000, "R1 in reset"));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare(ref_exp(5'b00000, "R1 after release"));

    // R3 / R2: hold and walk the ring, distractor inputs included
    cyc(0, 1, 1, 0, 5'b0, "R3 A holds without go");
    cyc(1, 0, 0, 0, 5'b0, "R2 R3 A->B");
    cyc(1, 0, 1, 0, 5'b0, "R3 B holds without step");
    cyc(0, 1, 0, 0, 5'b0, "R2 R3 B->C");
    cyc(1, 0, 1, 0, 5'b0, "R3 C holds without step");
    cyc(0, 1, 0, 0, 5'b0, "R2 R3 C->D");
    cyc(1, 1, 0, 0, 5'b0, "R3 D holds without done");
    cyc(0, 0, 1, 0, 5'b0, "R2 R3 D->A");

    // R4 R5 R8 R9: every single flip in every state, then a hold cycle
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        move_to(s);
        cyc(1, 1, 1, 1, 5'(1 << k), "R8 R4 R5 single flip decodes same state");
        cyc(0, 0, 0, 0, 5'b0, "R5 R9 base word rewritten");
      end
    end

    // R6: transitions taken directly from neighbour words
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k += 2) begin
        move_to(s);
        cyc(0, 0, 0, 1, 5'(1 << k), "R8 flip before advance");
        cyc(s == 0, s == 1 || s == 2, s == 3, 0, 5'b0, "R6 advance from neighbour");
      end
    end

    // R7: every orphan pattern, with go high to show controls are ignored
    for (int p = 0; p < 32; p++) begin
      if (ref_state(5'(p)) < 0) begin
        move_to(0);
        cyc(0, 0, 0, 1, 5'(p), "R7 R8 orphan pattern flagged");
        cyc(1, 1, 1, 0, 5'b0, "R7 orphan recovers to A");
      end
    end

    // Double flips that land in another state's group
    move_to(1);
    cyc(0, 0, 0, 1, 5'b00011, "R8 double flip from B");
    cyc(0, 0, 0, 0, 5'b0, "R9 settle after double flip");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule